// File: doc/BRIEF.md
# DMA Channel Start and Interrupt Register Block

This block is the register-facing control side of a seven-channel DMA engine. For each channel it holds three 32-bit registers: a memory address, a block control word and a channel control word. It also holds one shared per-channel enable word and one shared interrupt word. Software reaches all of these through a single write port and a combinational read port, both addressed by byte offset. Data movement is not part of this block. A downstream engine receives a one-cycle start pulse that carries the channel number and the three register values of that channel.

A transfer is launched by writing the channel control word with its start bit set. The channel's enable bit in the shared enable word must also be set. Channel 5 has registers but is never started. The interrupt word combines fields that software can write with per-channel completion flags that hardware raises. Software clears a flag by writing 1 to it. When the interrupt condition becomes true, the block sends a single pulse toward the interrupt controller. It sends no further pulse until the condition has gone false again.

Top module: `dmaStartIrq`

## Requirements
- R1: After reset every mapped register reads 0, and neither startValid nor irqPulse is asserted.
- R2: Channel n (0 to 6) has its address register at offset 0x80+0x10·n, its block register at +4 and its control register at +8. All three read back what was last written. Offset +0xC of a channel slot, offsets below 0x80 and offsets above 0xF4 read 0 and ignore writes.
- R3: The shared enable register at offset 0xF0 stores and reads back all 32 bits.
- R4: A write to channel n's control register with bit 24 set, while enable bit 4·n+3 is 1, makes startValid high for exactly the next cycle. In that cycle startChan=n, startAddr and startBlock hold channel n's registers, and startCtrl holds the written value.
- R5: A control-register write with bit 24 clear, or with enable bit 4·n+3 clear, produces no start pulse.
- R6: Channel 5 never produces a start pulse, whatever is written.
- R7: A write to the interrupt register at 0xF4 loads the written bits selected by mask 0x00FF803F. Bits 22..16 are per-channel flag enables, bit 23 is the master enable and bit 15 is the bus-error bit. All other bits except the flags and bit 31 read 0.
- R8: Flag bits 30..24 keep their value when written as 0 and clear when written as 1.
- R9: When chanDone[n] is high and enable bit 16+n is set, flag bit 24+n becomes 1 at the next edge. When the enable bit is clear, nothing changes.
- R10: The condition is (bit 23 set and any flag set) or bit 15 set. When it becomes true while read-only bit 31 is clear, irqPulse is high for one cycle, one cycle after the causing write or done input, and bit 31 reads 1.
- R11: While the condition stays true no further irqPulse occurs. Bit 31 clears once the condition is false, and this re-arms the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Byte offset of the combinational read |
| rdData | output | 32 | Read data |
| chanDone | input | 7 | Per-channel completion strobes |
| startValid | output | 1 | One-cycle start pulse |
| startChan | output | 3 | Channel being started |
| startAddr | output | 32 | Address register of that channel |
| startBlock | output | 32 | Block register of that channel |
| startCtrl | output | 32 | Control value that was written |
| irqPulse | output | 1 | One-cycle pulse toward interrupt input 3 |

## Verification
The assertions take for granted that at most one register write arrives per cycle. They also assume write offsets are word aligned, so that a start can only follow a control-slot write at offset +8 of a channel with bit 24 set. The stimulus uses only aligned offsets on the single write port and holds chanDone low except in the cycles that model a completion. The interrupt scenarios walk the sent bit through its set, hold and re-arm states. This is the path where a repeated pulse would break the one-pulse property.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int CHAN_COUNT = 7;
  localparam int DATA_W = 32;
  localparam int CHAN_IDX_W = $clog2(CHAN_COUNT);
  localparam int SILENT_CHAN = 5;

  localparam logic [7:0] CHAN_BASE = 8'h80;
  localparam logic [7:0] CHAN_STRIDE = 8'h10;
  localparam logic [7:0] OFS_ADDR = 8'h0;
  localparam logic [7:0] OFS_BLOCK = 8'h4;
  localparam logic [7:0] OFS_CTRL = 8'h8;
  localparam logic [7:0] ENABLE_OFS = 8'hF0;
  localparam logic [7:0] INT_OFS = 8'hF4;

  localparam int START_BIT = 24;
  localparam logic [DATA_W-1:0] INT_WR_MASK = 32'h00FF_803F;
  localparam logic [DATA_W-1:0] INT_FLAG_MASK = 32'h7F00_0000;
  localparam int FLAG_LSB = 24;
  localparam int FLAG_EN_LSB = 16;
  localparam int MASTER_BIT = 23;
  localparam int BUSERR_BIT = 15;
  localparam int SENT_BIT = 31;

  typedef struct packed {
    logic [CHAN_COUNT-1:0] addrWe;
    logic [CHAN_COUNT-1:0] blockWe;
    logic [CHAN_COUNT-1:0] ctrlWe;
    logic                  enableWe;
    logic                  intWe;
    logic                  startGo;
    logic [CHAN_IDX_W-1:0] chanIdx;
  } regStrobes_t;

  function automatic logic [7:0] chanOfs(input int n, input logic [7:0] field);
    return 8'(CHAN_BASE + 8'(n) * CHAN_STRIDE + field);
  endfunction
endpackage

// File: rtl/dmaRegDecode.sv
module dmaRegDecode
  import dmaRegPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] enableQ,
  output regStrobes_t       strobes
);
  logic       hiZero;
  logic [7:0] lowAddr;

  assign lowAddr = wrAddr[7:0];

  generate
    if (ADDR_W > 8) begin : g_hi
      assign hiZero = ~|wrAddr[ADDR_W-1:8];
    end else begin : g_nohi
      assign hiZero = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes = '0;
    if (wrEn && hiZero) begin
      for (int n = 0; n < CHAN_COUNT; n++) begin
        if (lowAddr == chanOfs(n, OFS_ADDR))  strobes.addrWe[n]  = 1'b1;
        if (lowAddr == chanOfs(n, OFS_BLOCK)) strobes.blockWe[n] = 1'b1;
        if (lowAddr == chanOfs(n, OFS_CTRL))  strobes.ctrlWe[n]  = 1'b1;
      end
      strobes.enableWe = (lowAddr == ENABLE_OFS);
      strobes.intWe    = (lowAddr == INT_OFS);
    end
    // start gating: start bit in data, per-channel enable, silent channel excluded
    for (int n = 0; n < CHAN_COUNT; n++) begin
      if (strobes.ctrlWe[n] && wrData[START_BIT] && enableQ[4*n+3] && n != SILENT_CHAN) begin
        strobes.startGo = 1'b1;
        strobes.chanIdx = CHAN_IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/dmaIntReg.sv
module dmaIntReg
  import dmaRegPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  intWe,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [CHAN_COUNT-1:0] chanDone,
  output logic [DATA_W-1:0]     intQ,
  output logic                  irqPulse
);
  logic [DATA_W-1:0] merged;
  logic              irqCond;

  always_comb begin
    if (intWe) begin
      merged = (wrData & INT_WR_MASK) | (intQ & ~wrData & INT_FLAG_MASK);
    end else begin
      merged = intQ & (INT_WR_MASK | INT_FLAG_MASK);
    end
    merged[FLAG_LSB +: CHAN_COUNT] = merged[FLAG_LSB +: CHAN_COUNT]
                                   | (chanDone & merged[FLAG_EN_LSB +: CHAN_COUNT]);
    irqCond = (merged[MASTER_BIT] && (|merged[FLAG_LSB +: CHAN_COUNT])) || merged[BUSERR_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intQ     <= '0;
      irqPulse <= 1'b0;
    end else begin
      intQ           <= merged;
      intQ[SENT_BIT] <= irqCond;
      irqPulse       <= irqCond && !intQ[SENT_BIT];
    end
  end
endmodule

// File: rtl/dmaChanRegs.sv
module dmaChanRegs
  import dmaRegPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobes_t           strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [DATA_W-1:0]     intQ,
  output logic [DATA_W-1:0]     enableQ,
  output logic [DATA_W-1:0]     rdData,
  output logic                  startValid,
  output logic [CHAN_IDX_W-1:0] startChan,
  output logic [DATA_W-1:0]     startAddr,
  output logic [DATA_W-1:0]     startBlock,
  output logic [DATA_W-1:0]     startCtrl
);
  logic [DATA_W-1:0] addrQ  [CHAN_COUNT];
  logic [DATA_W-1:0] blockQ [CHAN_COUNT];
  logic [DATA_W-1:0] ctrlQ  [CHAN_COUNT];
  logic              rdHiZero;
  logic [7:0]        rdLow;

  genvar gi;
  generate
    for (gi = 0; gi < CHAN_COUNT; gi++) begin : g_chan
      always_ff @(posedge clk) begin
        if (!rstN) begin
          addrQ[gi]  <= '0;
          blockQ[gi] <= '0;
          ctrlQ[gi]  <= '0;
        end else begin
          if (strobes.addrWe[gi])  addrQ[gi]  <= wrData;
          if (strobes.blockWe[gi]) blockQ[gi] <= wrData;
          if (strobes.ctrlWe[gi])  ctrlQ[gi]  <= wrData;
        end
      end
    end
    if (ADDR_W > 8) begin : g_rdhi
      assign rdHiZero = ~|rdAddr[ADDR_W-1:8];
    end else begin : g_rdnohi
      assign rdHiZero = 1'b1;
    end
  endgenerate

  assign rdLow = rdAddr[7:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ    <= '0;
      startValid <= 1'b0;
      startChan  <= '0;
      startAddr  <= '0;
      startBlock <= '0;
      startCtrl  <= '0;
    end else begin
      if (strobes.enableWe) enableQ <= wrData;
      startValid <= strobes.startGo;
      if (strobes.startGo) begin
        startChan  <= strobes.chanIdx;
        startAddr  <= addrQ[strobes.chanIdx];
        startBlock <= blockQ[strobes.chanIdx];
        startCtrl  <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdHiZero) begin
      for (int n = 0; n < CHAN_COUNT; n++) begin
        if (rdLow == chanOfs(n, OFS_ADDR))  rdData = addrQ[n];
        if (rdLow == chanOfs(n, OFS_BLOCK)) rdData = blockQ[n];
        if (rdLow == chanOfs(n, OFS_CTRL))  rdData = ctrlQ[n];
      end
      if (rdLow == ENABLE_OFS) rdData = enableQ;
      if (rdLow == INT_OFS)    rdData = intQ;
    end
  end
endmodule

// File: rtl/dmaStartIrq.sv
module dmaStartIrq
  import dmaRegPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  input  logic [CHAN_COUNT-1:0] chanDone,
  output logic                  startValid,
  output logic [CHAN_IDX_W-1:0] startChan,
  output logic [DATA_W-1:0]     startAddr,
  output logic [DATA_W-1:0]     startBlock,
  output logic [DATA_W-1:0]     startCtrl,
  output logic                  irqPulse
);
  regStrobes_t       strobes;
  logic [DATA_W-1:0] enableQ;
  logic [DATA_W-1:0] intQ;

  dmaRegDecode #(.ADDR_W(ADDR_W)) u_decode (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .enableQ(enableQ), .strobes(strobes)
  );

  dmaChanRegs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .rdAddr(rdAddr),
    .intQ(intQ), .enableQ(enableQ), .rdData(rdData), .startValid(startValid),
    .startChan(startChan), .startAddr(startAddr), .startBlock(startBlock),
    .startCtrl(startCtrl)
  );

  dmaIntReg u_int (
    .clk(clk), .rstN(rstN), .intWe(strobes.intWe), .wrData(wrData),
    .chanDone(chanDone), .intQ(intQ), .irqPulse(irqPulse)
  );
endmodule

// File: rtl/dmaStartIrqChk.sv
module dmaStartIrqChk
  import dmaRegPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic [DATA_W-1:0]     wrData,
  input logic                  startValid,
  input logic [CHAN_IDX_W-1:0] startChan,
  input logic [DATA_W-1:0]     enableQ,
  input logic [DATA_W-1:0]     intQ,
  input logic                  irqPulse
);
  assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> $past(wrEn && wrData[START_BIT] && wrAddr[3:0] == 4'h8 && wrAddr[7]));

  assert_start_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> enableQ[{startChan, 2'b11}]);

  assert_no_silent_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> startChan != CHAN_IDX_W'(SILENT_CHAN));

  assert_irq_marks_sent_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> intQ[SENT_BIT]);

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
endmodule

bind dmaStartIrq dmaStartIrqChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .startValid(startValid), .startChan(startChan), .enableQ(enableQ), .intQ(intQ),
  .irqPulse(irqPulse)
);

// File: tb/test_dmaStartIrq.sv
module test_dmaStartIrq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [6:0]  chanDone = '0;
  logic        startValid;
  logic [2:0]  startChan;
  logic [31:0] startAddr, startBlock, startCtrl;
  logic        irqPulse;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] mAddr [7];
  logic [31:0] mBlock [7];
  logic [31:0] mCtrl [7];
  logic [31:0] mEnable;
  logic [31:0] mInt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaStartIrq #(.ADDR_W(8)) i_dmaStartIrq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .chanDone(chanDone), .startValid(startValid),
    .startChan(startChan), .startAddr(startAddr), .startBlock(startBlock),
    .startCtrl(startCtrl), .irqPulse(irqPulse)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    logic [31:0] v = '0;
    for (int n = 0; n < 7; n++) begin
      if (a == 8'(8'h80 + 16 * n))     v = mAddr[n];
      if (a == 8'(8'h80 + 16 * n + 4)) v = mBlock[n];
      if (a == 8'(8'h80 + 16 * n + 8)) v = mCtrl[n];
    end
    if (a == 8'hF0) v = mEnable;
    if (a == 8'hF4) v = mInt;
    return v;
  endfunction

  task automatic cycle(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [6:0] done, input logic [7:0] ra, input string tag);
    bit expStart = 0;
    int expChan = 0;
    logic [31:0] expSA = '0, expSB = '0, expSC = '0;
    logic [31:0] t;
    bit cond, expIrq;
    wrEn = we; wrAddr = a; wrData = d; chanDone = done; rdAddr = ra;
    #2;
    check(tag, "rdData", rdData, modelRead(ra));
    // interrupt word next value
    if (we && a == 8'hF4) t = (d & 32'h00FF803F) | (mInt & ~d & 32'h7F000000);
    else t = mInt & 32'h7FFF803F;
    for (int n = 0; n < 7; n++)
      if (done[n] && t[16+n]) t[24+n] = 1'b1;
    cond = (t[23] && (t[30:24] != 0)) || t[15];
    expIrq = cond && !mInt[31];
    t[31] = cond;
    if (we) begin
      for (int n = 0; n < 7; n++) begin
        if (a == 8'(8'h80 + 16 * n)) mAddr[n] = d;
        if (a == 8'(8'h80 + 16 * n + 4)) mBlock[n] = d;
        if (a == 8'(8'h80 + 16 * n + 8)) begin
          mCtrl[n] = d;
          if (d[24] && mEnable[4*n+3] && n != 5) begin
            expStart = 1; expChan = n; expSA = mAddr[n]; expSB = mBlock[n]; expSC = d;
          end
        end
      end
      if (a == 8'hF0) mEnable = d;
    end
    mInt = t;
    @(posedge clk);
    #1;
    check(tag, "startValid", 32'(startValid), 32'(expStart));
    if (expStart) begin
      check(tag, "startChan", 32'(startChan), 32'(expChan));
      check(tag, "startAddr", startAddr, expSA);
      check(tag, "startBlock", startBlock, expSB);
      check(tag, "startCtrl", startCtrl, expSC);
    end
    check(tag, "irqPulse", 32'(irqPulse), 32'(expIrq));
    wrEn = 1'b0; chanDone = '0;
  endtask

  task automatic idle(input logic [7:0] ra, input string tag);
    cycle(0, 8'h00, 32'h0, 7'h0, ra, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int n = 0; n < 7; n++) begin
      mAddr[n] = '0; mBlock[n] = '0; mCtrl[n] = '0;
    end
    mEnable = '0; mInt = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    idle(8'h80, "R1"); idle(8'hF0, "R1"); idle(8'hF4, "R1"); idle(8'hE8, "R1");
    // R2: register file, control bit 24 clear so no start (R5)
    for (int n = 0; n < 7; n++) begin
      cycle(1, 8'(8'h80 + 16 * n), 32'h1000 * (n + 1), 7'h0, 8'h80, "R2");
      cycle(1, 8'(8'h84 + 16 * n), 32'h20 + n, 7'h0, 8'(8'h80 + 16 * n), "R2");
      cycle(1, 8'(8'h88 + 16 * n), 32'h0000_0200 + n, 7'h0, 8'(8'h84 + 16 * n), "R5");
      idle(8'(8'h88 + 16 * n), "R2");
    end
    cycle(1, 8'h8C, 32'hDEAD_BEEF, 7'h0, 8'h8C, "R2");
    cycle(1, 8'h10, 32'hDEAD_BEEF, 7'h0, 8'h8C, "R2");
    cycle(1, 8'hF8, 32'hDEAD_BEEF, 7'h0, 8'h10, "R2");
    idle(8'hF8, "R2");
    // R5: start bit set but channels disabled
    cycle(1, 8'h98, 32'h0100_0001, 7'h0, 8'h98, "R5");
    // R3: enable register
    cycle(1, 8'hF0, 32'h0888_8888, 7'h0, 8'hF0, "R3");
    idle(8'hF0, "R3");
    // R4 / R6: start every channel, channel 5 silent
    for (int n = 0; n < 7; n++)
      cycle(1, 8'(8'h88 + 16 * n), 32'h0100_0000 | (n << 4), 7'h0, 8'h88,
            (n == 5) ? "R6" : "R4");
    cycle(1, 8'hB8, 32'h0100_0ABC, 7'h0, 8'hB8, "R4");
    cycle(1, 8'hC8, 32'h0100_0001, 7'h0, 8'hC8, "R4");
    // R5: clear channel 2 enable only
    cycle(1, 8'hF0, 32'h0888_8088, 7'h0, 8'hF0, "R5");
    cycle(1, 8'hA8, 32'h0100_0002, 7'h0, 8'hA8, "R5");
    cycle(1, 8'hB8, 32'h0100_0003, 7'h0, 8'hB8, "R4");
    // R7 / R10: write all ones, bus error triggers
    cycle(1, 8'hF4, 32'hFFFF_FFFF, 7'h0, 8'hF4, "R7");
    idle(8'hF4, "R10"); idle(8'hF4, "R11");
    // R11: drop bus error, keep enables and master: condition false, re-armed
    cycle(1, 8'hF4, 32'h00FF_0000, 7'h0, 8'hF4, "R11");
    idle(8'hF4, "R11");
    // R9 / R10: completion on channel 3
    cycle(0, 8'h00, 32'h0, 7'b000_1000, 8'hF4, "R9");
    idle(8'hF4, "R10");
    cycle(0, 8'h00, 32'h0, 7'b000_0010, 8'hF4, "R11");
    idle(8'hF4, "R11");
    // R8: clear flag 27, flag 25 stays, no new pulse
    cycle(1, 8'hF4, 32'h08FF_0000, 7'h0, 8'hF4, "R8");
    idle(8'hF4, "R8");
    cycle(1, 8'hF4, 32'h02FF_0000, 7'h0, 8'hF4, "R8");
    idle(8'hF4, "R8");
    // R9: done with per-channel enable clear does nothing
    cycle(1, 8'hF4, 32'h0080_0000, 7'h0, 8'hF4, "R9");
    cycle(0, 8'h00, 32'h0, 7'b111_1111, 8'hF4, "R9");
    idle(8'hF4, "R9");
    // R11: re-arm and fire again from channel 0
    cycle(1, 8'hF4, 32'h0081_0000, 7'b000_0001, 8'hF4, "R11");
    idle(8'hF4, "R10");
    // R10: flags without master enable do not fire
    cycle(1, 8'hF4, 32'h0101_0000, 7'h0, 8'hF4, "R10");
    cycle(0, 8'h00, 32'h0, 7'b000_0001, 8'hF4, "R10");
    idle(8'hF4, "R10");
    cycle(1, 8'hF4, 32'h0081_0000, 7'h0, 8'hF4, "R10");
    idle(8'hF4, "R10");
    finish_run();
  end
endmodule